// File: doc/BRIEF.md
# Twin-Region Stream Path Switch

This block sits in front of and behind one stage of a streaming pipeline that is built from two identical, swappable processing regions. At any time one region is active and carries all live traffic. The other region is idle, so it can be loaded with a new processing function while the active one keeps working. The switch sends every input beat to the active region only, and it forwards only the active region's output downstream. Both sides use valid/ready streams with a last-beat flag that marks the end of each frame.

Software asks for a hand-over by pulsing a request. The idle region signals through its own loaded flag that it has finished loading. The hand-over is granted only when the request is pending, the idle region is loaded, and the input is between frames. After the grant, the switch stops admitting new frames. It then waits until every frame that was already given to the old region has left that region's output. Only then does it flip the active selection and open the input again, now towards the new region. Loading the idle region therefore overlaps live processing, and the pipeline pauses only for the drain of the frames still in flight.

Top module: `twin_region_switch`

## Requirements
- R1: After reset, region 0 is active (`active_o` = 0), no hand-over is pending, and the input is open to region 0.
- R2: An input beat goes only to the active region: `reg_in_valid_o[i]` is 1 only for i = `active_o`. Data and last flag are passed through unchanged, and `in_ready_o` follows the active region's ready while admission is open.
- R3: The output shows only the active region's valid, data (slice i of `reg_out_data_i`, bits i*DATA_W and up) and last flag. `reg_out_ready_o` is low for the idle region and equals `out_ready_i` for the active one.
- R4: A pulse on `sw_req_i` sets a pending request. The hand-over is granted only while the idle region's `region_loaded_i` bit is 1. A request made while that bit is 0 stays pending and is granted in the first cycle after the bit rises, provided no frame is partly admitted.
- R5: A grant never falls inside a frame. While a frame has been partly admitted (an accepted beat with last = 0 that has no accepted last beat after it yet), input stays open and the frame completes on the old region.
- R6: From the grant cycle until the active selection flips, `in_ready_o` is 0 and no input beat reaches either region.
- R7: The selection flips only when every frame admitted to the old region has had its last beat accepted at the output. While frames are still held inside the old region, `active_o` does not change.
- R8: `active_o` toggles exactly once per grant. A request pulse seen after the grant, before the flip, has no effect.
- R9: After the flip, new frames enter the newly active region and its output is forwarded. The previously active region receives no further beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req_i | input | 1 | Hand-over request pulse |
| region_loaded_i | input | 2 | Per-region loading-finished flag |
| active_o | output | 1 | Index of the region carrying traffic |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high with valid |
| in_data_i | input | DATA_W | Input beat payload |
| in_last_i | input | 1 | Input beat ends its frame |
| reg_in_valid_o | output | 2 | Per-region input valid |
| reg_in_ready_i | input | 2 | Per-region input ready |
| reg_in_data_o | output | DATA_W | Payload offered to the regions |
| reg_in_last_o | output | 1 | Last flag offered to the regions |
| reg_out_valid_i | input | 2 | Per-region output valid |
| reg_out_ready_o | output | 2 | Per-region output ready |
| reg_out_data_i | input | 2*DATA_W | Region outputs, region i in slice i |
| reg_out_last_i | input | 2 | Per-region output last flag |
| out_valid_o | output | 1 | Merged output valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | DATA_W | Merged output payload |
| out_last_o | output | 1 | Merged output last flag |

## Verification
The hardest case to reach is a hand-over that has been granted but cannot finish yet: the request must arrive in the middle of a frame, and the old region must still hold that frame after its last beat has entered. The bench models each region as a queue whose output it can freeze. It starts a frame, sends the request between beats, completes the frame, and keeps the old region's output frozen for several cycles. During that window it checks that the input stays closed and the selection stays put. A second request is sent inside the same window. The bench then releases the output and checks for a single flip, and that a following frame lands in the other region.

// File: rtl/twin_switch_pkg.sv
package twin_switch_pkg;
   localparam int unsigned NUM_REGIONS = 2;

   typedef enum logic {
      SW_RUN   = 1'b0,
      SW_DRAIN = 1'b1
   } sw_state_e;
endpackage

// File: rtl/tws_frame_tally.sv
module tws_frame_tally #(
   parameter int unsigned MAX_FRAMES = 4,
   localparam int unsigned CNT_W = $clog2(MAX_FRAMES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_fire,
   input  logic             in_last,
   input  logic             out_fire,
   input  logic             out_last,
   output logic             mid_frame,
   output logic [CNT_W-1:0] frames_held,
   output logic             drained
);
   logic frame_in;
   logic frame_out;

   assign frame_in  = in_fire & in_last;
   assign frame_out = out_fire & out_last;

   // partial-frame flag on the input side
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mid_frame <= 1'b0;
      end else if (in_fire) begin
         mid_frame <= ~in_last;
      end
   end

   // completed frames admitted minus frames finished at the output
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frames_held <= '0;
      end else if (frame_in && !frame_out) begin
         frames_held <= frames_held + 1'b1;
      end else if (frame_out && !frame_in) begin
         frames_held <= frames_held - 1'b1;
      end
   end

   assign drained = (frames_held == '0) && !mid_frame;
endmodule

// File: rtl/tws_swap_ctrl.sv
module tws_swap_ctrl
   import twin_switch_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sw_req,
   input  logic [NUM_REGIONS-1:0] loaded,
   input  logic                   mid_frame,
   input  logic                   drained,
   output logic                   active,
   output logic                   pending,
   output logic                   grant,
   output logic                   draining,
   output logic                   admit_open
);
   sw_state_e state;
   logic      idle_loaded;

   assign idle_loaded = loaded[~active];
   assign draining    = (state == SW_DRAIN);
   assign grant       = (state == SW_RUN) && pending && idle_loaded && !mid_frame;
   assign admit_open  = (state == SW_RUN) && !grant;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SW_RUN;
         active  <= 1'b0;
         pending <= 1'b0;
      end else begin
         unique case (state)
            SW_RUN: begin
               if (grant) begin
                  state <= SW_DRAIN;
               end else if (sw_req) begin
                  pending <= 1'b1;
               end
            end
            SW_DRAIN: begin
               if (drained) begin
                  active  <= ~active;
                  pending <= 1'b0;
                  state   <= SW_RUN;
               end
            end
            default: state <= SW_RUN;
         endcase
      end
   end
endmodule

// File: rtl/tws_route.sv
module tws_route
   import twin_switch_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                          active,
   input  logic                          admit_open,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [DATA_W-1:0]             in_data,
   input  logic                          in_last,
   output logic [NUM_REGIONS-1:0]        reg_in_valid,
   input  logic [NUM_REGIONS-1:0]        reg_in_ready,
   output logic [DATA_W-1:0]             reg_in_data,
   output logic                          reg_in_last,
   input  logic [NUM_REGIONS-1:0]        reg_out_valid,
   output logic [NUM_REGIONS-1:0]        reg_out_ready,
   input  logic [NUM_REGIONS*DATA_W-1:0] reg_out_data,
   input  logic [NUM_REGIONS-1:0]        reg_out_last,
   output logic                          out_valid,
   input  logic                          out_ready,
   output logic [DATA_W-1:0]             out_data,
   output logic                          out_last
);
   logic [NUM_REGIONS-1:0] sel;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
      assign sel[g]           = (active == 1'(g));
      assign reg_in_valid[g]  = in_valid & admit_open & sel[g];
      assign reg_out_ready[g] = out_ready & sel[g];
   end

   assign reg_in_data = in_data;
   assign reg_in_last = in_last;
   assign in_ready    = admit_open & reg_in_ready[active];

   always_comb begin
      out_valid = 1'b0;
      out_data  = '0;
      out_last  = 1'b0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (sel[i]) begin
            out_valid = reg_out_valid[i];
            out_data  = reg_out_data[i*DATA_W +: DATA_W];
            out_last  = reg_out_last[i];
         end
      end
   end
endmodule

// File: rtl/twin_region_switch.sv
module twin_region_switch
   import twin_switch_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned MAX_FRAMES = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sw_req_i,
   input  logic [1:0]             region_loaded_i,
   output logic                   active_o,
   input  logic                   in_valid_i,
   output logic                   in_ready_o,
   input  logic [DATA_W-1:0]      in_data_i,
   input  logic                   in_last_i,
   output logic [1:0]             reg_in_valid_o,
   input  logic [1:0]             reg_in_ready_i,
   output logic [DATA_W-1:0]      reg_in_data_o,
   output logic                   reg_in_last_o,
   input  logic [1:0]             reg_out_valid_i,
   output logic [1:0]             reg_out_ready_o,
   input  logic [2*DATA_W-1:0]    reg_out_data_i,
   input  logic [1:0]             reg_out_last_i,
   output logic                   out_valid_o,
   input  logic                   out_ready_i,
   output logic [DATA_W-1:0]      out_data_o,
   output logic                   out_last_o
);
   localparam int unsigned CNT_W = $clog2(MAX_FRAMES + 1);

   if (DATA_W < 1) begin : g_bad_width
      $error("twin_region_switch: DATA_W must be at least 1");
   end
   if (MAX_FRAMES < 1) begin : g_bad_frames
      $error("twin_region_switch: MAX_FRAMES must be at least 1");
   end
   if (NUM_REGIONS != 2) begin : g_bad_regions
      $error("twin_region_switch: exactly two regions are supported");
   end

   logic             admit_open_w;
   logic             mid_w;
   logic             drained_w;
   logic             pending_w;
   logic             grant_w;
   logic             drain_w;
   logic [CNT_W-1:0] held_w;

   tws_swap_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_req     (sw_req_i),
      .loaded     (region_loaded_i),
      .mid_frame  (mid_w),
      .drained    (drained_w),
      .active     (active_o),
      .pending    (pending_w),
      .grant      (grant_w),
      .draining   (drain_w),
      .admit_open (admit_open_w)
   );

   tws_route #(.DATA_W(DATA_W)) u_route (
      .active        (active_o),
      .admit_open    (admit_open_w),
      .in_valid      (in_valid_i),
      .in_ready      (in_ready_o),
      .in_data       (in_data_i),
      .in_last       (in_last_i),
      .reg_in_valid  (reg_in_valid_o),
      .reg_in_ready  (reg_in_ready_i),
      .reg_in_data   (reg_in_data_o),
      .reg_in_last   (reg_in_last_o),
      .reg_out_valid (reg_out_valid_i),
      .reg_out_ready (reg_out_ready_o),
      .reg_out_data  (reg_out_data_i),
      .reg_out_last  (reg_out_last_i),
      .out_valid     (out_valid_o),
      .out_ready     (out_ready_i),
      .out_data      (out_data_o),
      .out_last      (out_last_o)
   );

   tws_frame_tally #(.MAX_FRAMES(MAX_FRAMES)) u_tally (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_fire     (in_valid_i & in_ready_o),
      .in_last     (in_last_i),
      .out_fire    (out_valid_o & out_ready_i),
      .out_last    (out_last_o),
      .mid_frame   (mid_w),
      .frames_held (held_w),
      .drained     (drained_w)
   );
endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
   parameter int unsigned CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             active_o,
   input logic             in_ready_o,
   input logic [1:0]       reg_in_valid_o,
   input logic [1:0]       reg_out_ready_o,
   input logic [1:0]       region_loaded_i,
   input logic             drain,
   input logic             mid,
   input logic [CNT_W-1:0] held
);
   // R2: the idle region never sees a valid beat
   a_r2_idle_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_in_valid_o[~active_o]);

   // R3: the idle region is never drained
   a_r3_idle_output_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_out_ready_o[~active_o]);

   // R4: a grant needs the idle region loaded
   a_r4_grant_needs_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drain) |-> $past(region_loaded_i[~active_o]));

   // R5: a grant never starts inside a frame
   a_r5_grant_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drain) |-> !$past(mid));

   // R6: admission closed while draining
   a_r6_closed_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
      drain |-> (!in_ready_o && reg_in_valid_o == 2'b00));

   // R7: flip only with nothing held in the old region
   a_r7_flip_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active_o) |-> ($past(held) == '0));

   // R8: a flip always ends a drain
   a_r8_flip_ends_drain: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active_o) |-> ($past(drain) && !drain));
endmodule

bind twin_region_switch tws_checker #(.CNT_W(CNT_W)) u_tws_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .active_o        (active_o),
   .in_ready_o      (in_ready_o),
   .reg_in_valid_o  (reg_in_valid_o),
   .reg_out_ready_o (reg_out_ready_o),
   .region_loaded_i (region_loaded_i),
   .drain           (drain_w),
   .mid             (mid_w),
   .held            (held_w)
);

// File: tb/test_twin_region_switch.sv
module test_twin_region_switch;
   localparam int DW = 8;
   localparam logic [7:0] TAG0 = 8'h40;
   localparam logic [7:0] TAG1 = 8'h80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_req_i = 1'b0;
   logic [1:0]    region_loaded_i = 2'b00;
   logic          active_o;
   logic          in_valid_i = 1'b0;
   logic          in_ready_o;
   logic [DW-1:0] in_data_i = '0;
   logic          in_last_i = 1'b0;
   logic [1:0]    reg_in_valid_o;
   logic [1:0]    reg_in_ready_i = 2'b11;
   logic [DW-1:0] reg_in_data_o;
   logic          reg_in_last_o;
   logic [1:0]    reg_out_valid_i;
   logic [1:0]    reg_out_ready_o;
   logic [2*DW-1:0] reg_out_data_i;
   logic [1:0]    reg_out_last_i;
   logic          out_valid_o;
   logic          out_ready_i = 1'b1;
   logic [DW-1:0] out_data_o;
   logic          out_last_o;

   logic [1:0] hold = 2'b00;
   int checks = 0;
   int errors = 0;
   int pushes [2];
   logic [DW-1:0] got_data [64];
   logic          got_last [64];
   int n_got = 0;

   always #2.5 clk = ~clk;

   twin_region_switch #(.DATA_W(DW), .MAX_FRAMES(4)) i_twin_region_switch (
      .clk(clk), .rst_n(rst_n), .sw_req_i(sw_req_i), .region_loaded_i(region_loaded_i),
      .active_o(active_o), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
      .in_data_i(in_data_i), .in_last_i(in_last_i), .reg_in_valid_o(reg_in_valid_o),
      .reg_in_ready_i(reg_in_ready_i), .reg_in_data_o(reg_in_data_o),
      .reg_in_last_o(reg_in_last_o), .reg_out_valid_i(reg_out_valid_i),
      .reg_out_ready_o(reg_out_ready_o), .reg_out_data_i(reg_out_data_i),
      .reg_out_last_i(reg_out_last_i), .out_valid_o(out_valid_o),
      .out_ready_i(out_ready_i), .out_data_o(out_data_o), .out_last_o(out_last_o)
   );

   // region models: queues that tag the payload with the region identity
   for (genvar r = 0; r < 2; r++) begin : g_reg
      logic [8:0] mem [64];
      logic [5:0] wp;
      logic [5:0] rp;
      logic [7:0] tag;
      assign tag = (r == 0) ? TAG0 : TAG1;
      assign reg_out_valid_i[r] = (wp != rp) && !hold[r];
      assign reg_out_data_i[r*DW +: DW] = mem[rp][7:0] ^ tag;
      assign reg_out_last_i[r] = mem[rp][8];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wp <= '0;
            rp <= '0;
         end else begin
            if (reg_in_valid_o[r] && reg_in_ready_i[r]) begin
               mem[wp] <= {reg_in_last_o, reg_in_data_o};
               wp <= wp + 1'b1;
               pushes[r] <= pushes[r] + 1;
            end
            if (reg_out_valid_i[r] && reg_out_ready_o[r]) rp <= rp + 1'b1;
         end
      end
   end

   // output collector, sampled well after the driving edge
   always @(negedge clk) begin
      #2;
      if (rst_n && out_valid_o && out_ready_i && n_got < 64) begin
         got_data[n_got] = out_data_o;
         got_last[n_got] = out_last_o;
         n_got = n_got + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic send_beat(input logic [7:0] d, input logic l);
      @(negedge clk);
      in_valid_i = 1'b1;
      in_data_i  = d;
      in_last_i  = l;
      #1;
      while (!in_ready_o) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
   endtask

   task automatic end_input();
      @(negedge clk);
      in_valid_i = 1'b0;
      in_last_i  = 1'b0;
   endtask

   task automatic pulse_req();
      @(negedge clk);
      sw_req_i = 1'b1;
      @(negedge clk);
      sw_req_i = 1'b0;
   endtask

   task automatic send_frame(input int n, input logic [7:0] base);
      for (int k = 0; k < n; k++) send_beat(base + 8'(k), (k == n - 1));
      end_input();
   endtask

   task automatic check_frame(input int start, input int n, input logic [7:0] base,
                              input logic [7:0] tag, input string req);
      for (int k = 0; k < n; k++) begin
         check(got_data[start+k] == ((base + 8'(k)) ^ tag), req,
               got_data[start+k], (base + 8'(k)) ^ tag);
         check(got_last[start+k] == (k == n - 1), req, got_last[start+k], (k == n - 1));
      end
   endtask

   task automatic t_reset();
      cycles(1);
      check(active_o == 1'b0, "R1 active after reset", active_o, 0);
      check(in_ready_o == 1'b1, "R1 input open", in_ready_o, 1);
      check(out_valid_o == 1'b0, "R1 no output", out_valid_o, 0);
   endtask

   task automatic t_pass_and_backpressure();
      int s;
      s = n_got;
      out_ready_i = 1'b0;
      send_frame(3, 8'h01);
      cycles(2);
      check(out_valid_o == 1'b1, "R3 output valid from active", out_valid_o, 1);
      check(reg_out_ready_o == 2'b00, "R3 ready gated downstream", reg_out_ready_o, 0);
      check(pushes[1] == 0, "R2 idle region untouched", pushes[1], 0);
      @(negedge clk);
      out_ready_i = 1'b1;
      cycles(6);
      check(n_got == s + 3, "R3 beat count", n_got - s, 3);
      check_frame(s, 3, 8'h01, TAG0, "R2 R3 region0 payload");
   endtask

   task automatic t_req_waits_load();
      int s;
      pulse_req();
      s = n_got;
      send_frame(2, 8'h08);
      cycles(6);
      check(active_o == 1'b0, "R4 held while unloaded", active_o, 0);
      check_frame(s, 2, 8'h08, TAG0, "R4 traffic continues");
      @(negedge clk);
      region_loaded_i[1] = 1'b1;
      #1;
      check(in_ready_o == 1'b0, "R6 closed in grant cycle", in_ready_o, 0);
      cycles(1);
      check(active_o == 1'b0 && in_ready_o == 1'b0, "R6 closed while draining",
            {active_o, in_ready_o}, 0);
      cycles(1);
      check(active_o == 1'b1, "R4 flip after load", active_o, 1);
      check(in_ready_o == 1'b1, "R9 input reopened", in_ready_o, 1);
   endtask

   task automatic t_mid_frame_drain();
      int s;
      int p1;
      @(negedge clk);
      region_loaded_i[0] = 1'b1;
      hold[1] = 1'b1;
      s = n_got;
      send_beat(8'h20, 1'b0);
      send_beat(8'h21, 1'b0);
      end_input();
      pulse_req();
      cycles(3);
      check(active_o == 1'b1, "R5 no flip mid-frame", active_o, 1);
      check(in_ready_o == 1'b1, "R5 input open mid-frame", in_ready_o, 1);
      send_beat(8'h22, 1'b0);
      send_beat(8'h23, 1'b1);
      end_input();
      #1;
      check(in_ready_o == 1'b0, "R6 closed after boundary", in_ready_o, 0);
      cycles(5);
      check(active_o == 1'b1, "R7 no flip while frame held", active_o, 1);
      check(in_ready_o == 1'b0, "R6 still closed", in_ready_o, 0);
      pulse_req();
      @(negedge clk);
      hold[1] = 1'b0;
      cycles(10);
      check(active_o == 1'b0, "R7 flip after drain", active_o, 0);
      check_frame(s, 4, 8'h20, TAG1, "R7 old region frame complete");
      cycles(10);
      check(active_o == 1'b0, "R8 single toggle", active_o, 0);
      p1 = pushes[1];
      s = n_got;
      send_frame(3, 8'h30);
      cycles(6);
      check_frame(s, 3, 8'h30, TAG0, "R9 new region carries traffic");
      check(pushes[1] == p1, "R9 old region idle", pushes[1], p1);
   endtask

   initial begin
      #(5.0 * 100000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      pushes[0] = 0;
      pushes[1] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_pass_and_backpressure();
      t_req_waits_load();
      t_mid_frame_drain();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule